// File: doc/BRIEF.md
# Shift, Rotate and Mask Execution Stage

This block is the combinational integer execution stage that handles shifts and rotates in a 64-bit processor datapath. The decoder presents an opcode, two mode flags (word width and signedness), the decoded rotate-mask fields and three operands. In the same cycle the stage returns a 64-bit result, a flag that says whether the opcode belongs to this unit, and a two-bit carry. The opcode and a small routing tag are passed back unchanged so the issue logic can steer the result.

The operations are logical left shift, logical and arithmetic right shift, sign-extend-word-then-shift-left, and a family of rotate-then-mask operations. Mask bit positions count from the most significant bit, so position 0 is bit 63. A run whose first position lies after its last position wraps around the word. The rotate that merges in a second operand serves as the insert form. The left-bounded and right-bounded clear forms discard that operand.

Top module: `srm_unit`

## Requirements
- R1: Opcode 1 is a left shift. With word mode clear, the amount is rb[6:0] and any amount of 64 or more gives zero. With word mode set, the amount is rb[5:0], the result is the low 32 bits of rs shifted by that amount, and bits 63:32 are zero.
- R2: Opcode 2 is a right shift. With word mode set, the source is rs[31:0], extended to 64 bits with its bit 31 when the signed flag is set and with zeros otherwise, and the amount is rb[5:0]. With word mode clear, the source is all of rs and the amount is rb[6:0]. The shift is arithmetic when the signed flag is set and logical otherwise. Amounts past the width leave only copies of the fill bit.
- R3: For a signed right shift, both carry bits are 1 exactly when the extended source is negative and at least one 1 bit was shifted out.
- R4: Every opcode other than a signed right shift, an unsigned right shift included, drives carry to 00.
- R5: A mask with first position F and last position L (position p is bit 63-p) has positions F through L set when F <= L. When F > L it has every position set except those strictly between L and F.
- R6: Opcode 3 with word mode set forms {rs[31:0], rs[31:0]}, rotates it left by rb[4:0], builds the mask with F = mb_word+32 and L = me_word+32, and returns (rotated & mask) | (ra & ~mask). The upper half is not cleared.
- R7: Opcode 3 with word mode clear rotates rs left by rb[5:0], builds the mask with F = decoded mb_dword and L = 63 - rb[5:0], and returns (rotated & mask) | (ra & ~mask).
- R8: The 6-bit mask fields mb_dword and me_dword are decoded as {field[0], field[5:1]}.
- R9: Opcode 4 rotates rs left by rb[5:0] and masks it with F = decoded mb_dword and L = 63. ra has no effect on the result.
- R10: Opcode 5 rotates rs left by rb[5:0] and masks it with F = 0 and L = decoded me_dword. ra has no effect on the result.
- R11: Opcode 6 sign-extends rs[31:0] to 64 bits and shifts it left by rb[5:0].
- R12: result_valid is 1 for opcodes 1 through 6. For opcodes 0 and 7 through 15 it is 0, and result and carry are zero. op_out always equals op_in and muxid_out always equals muxid_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 4 | Operation code |
| is_32bit | input | 1 | Word mode select |
| is_signed | input | 1 | Arithmetic right shift select |
| mb_word | input | 5 | First mask position of a word rotate |
| me_word | input | 5 | Last mask position of a word rotate |
| mb_dword | input | 6 | Encoded first mask position of doubleword rotates |
| me_dword | input | 6 | Encoded last mask position of doubleword rotates |
| rs | input | 64 | Source operand |
| ra | input | 64 | Insert operand for rotate-with-insert |
| rb | input | 64 | Shift or rotate amount |
| muxid_in | input | 2 | Routing tag |
| result | output | 64 | Operation result |
| result_valid | output | 1 | Opcode handled by this unit |
| carry | output | 2 | Carry out, both bits equal |
| op_out | output | 4 | Opcode passed through |
| muxid_out | output | 2 | Routing tag passed through |

## Verification
Shift amounts are tried at 0, 1, 31, 32, 63, 64 and 127, with garbage in the upper bits of rb. These values separate the word and doubleword amount fields and show where the result saturates. Right shifts use negative sources with zero and nonzero low bits, which is the only way to tell a carry from no carry, and they also use an unsigned negative source. The rotates use mask fields that produce a single bit, a full word and a wrapped run, and encoded fields that only decode correctly when the swizzle is applied. The clear forms and the invalid opcodes are driven with ra set to all ones, so any leak of ra shows up in the result. A randomised sweep over every opcode is checked against a bench model.

// File: rtl/srm_pkg.sv
`timescale 1ns/1ps
package srm_pkg;
   localparam int unsigned SRM_OPW = 4;

   typedef enum logic [SRM_OPW-1:0] {
      SRM_NONE  = 4'd0,
      SRM_SHL   = 4'd1,
      SRM_SHR   = 4'd2,
      SRM_ROTM  = 4'd3,
      SRM_ROTL  = 4'd4,
      SRM_ROTR  = 4'd5,
      SRM_EXTSL = 4'd6
   } srm_op_e;
endpackage

// File: rtl/srm_mask.sv
`timescale 1ns/1ps
// Run mask with MSB-first positions; wraps when the run start lies past its end.
module srm_mask #(
   parameter  int unsigned XLEN = 64,
   localparam int unsigned SHW  = $clog2(XLEN)
) (
   input  logic [SHW-1:0]  run_first,
   input  logic [SHW-1:0]  run_last,
   output logic [XLEN-1:0] mask
);
   logic ordered;
   assign ordered = (run_first <= run_last);

   for (genvar p = 0; p < XLEN; p++) begin : g_pos
      localparam logic [SHW-1:0] POS = SHW'(p);
      logic past_first, before_last;
      assign past_first  = (POS >= run_first);
      assign before_last = (POS <= run_last);
      assign mask[XLEN-1-p] = ordered ? (past_first & before_last)
                                      : (past_first | before_last);
   end

   always_comb begin
      if (run_first == run_last) begin
         AST_MASK_POINT: assert ($countones(mask) == 1) else $error("single-position mask has wrong population"); // R5
      end
      if (run_first == SHW'(run_last + 1'b1)) begin
         AST_MASK_FULL: assert (&mask) else $error("adjacent wrap must cover the word"); // R5
      end
   end
endmodule

// File: rtl/srm_shifter.sv
`timescale 1ns/1ps
// Left, right and sign-extend-then-left shifts with right-shift carry.
module srm_shifter
   import srm_pkg::*;
#(
   parameter  int unsigned XLEN = 64,
   localparam int unsigned SHW  = $clog2(XLEN),
   localparam int unsigned HALF = XLEN / 2,
   localparam int unsigned W2   = 2 * XLEN
) (
   input  srm_op_e         op,
   input  logic            is_32bit,
   input  logic            is_signed,
   input  logic [XLEN-1:0] rs,
   input  logic [SHW:0]    amt_in,
   output logic [XLEN-1:0] result,
   output logic [1:0]      carry
);
   logic [SHW:0]    amt;
   logic [XLEN-1:0] shl_full, shl_res;
   logic [XLEN-1:0] shr_src, ext_res;
   logic            src_neg, bits_lost;
   logic [W2-1:0]   wide_src, wide_shr, wide_back;

   assign amt = is_32bit ? {1'b0, amt_in[SHW-1:0]} : amt_in;

   // left shift: word mode keeps only the low half
   assign shl_full = rs << amt;
   assign shl_res  = is_32bit ? {{HALF{1'b0}}, shl_full[HALF-1:0]} : shl_full;

   // right shift on a double-width sign-filled copy; the round trip exposes lost ones
   assign shr_src   = is_32bit ? {{HALF{is_signed & rs[HALF-1]}}, rs[HALF-1:0]} : rs;
   assign src_neg   = is_signed & shr_src[XLEN-1];
   assign wide_src  = {{XLEN{src_neg}}, shr_src};
   assign wide_shr  = W2'($signed(wide_src) >>> amt);
   assign wide_back = wide_shr << amt;
   assign bits_lost = (wide_back != wide_src);

   assign ext_res = {{HALF{rs[HALF-1]}}, rs[HALF-1:0]} << amt_in[SHW-1:0];

   always_comb begin
      result = '0;
      carry  = 2'b00;
      case (op)
         SRM_SHL:   result = shl_res;
         SRM_SHR: begin
            result = wide_shr[XLEN-1:0];
            carry  = {2{src_neg & bits_lost}};
         end
         SRM_EXTSL: result = ext_res;
         default:   result = '0;
      endcase
   end

   always_comb begin
      if (carry != 2'b00) begin
         AST_CARRY_NEG: assert (op == SRM_SHR && is_signed && (is_32bit ? rs[HALF-1] : rs[XLEN-1])) else $error("carry without negative signed source"); // R3
      end
   end
endmodule

// File: rtl/srm_rotator.sv
`timescale 1ns/1ps
// Rotate-then-mask datapath for the insert and clear forms.
module srm_rotator
   import srm_pkg::*;
#(
   parameter  int unsigned XLEN = 64,
   localparam int unsigned SHW  = $clog2(XLEN),
   localparam int unsigned HSW  = SHW - 1,
   localparam int unsigned HALF = XLEN / 2
) (
   input  srm_op_e         op,
   input  logic            word_mode,
   input  logic [HSW-1:0]  first_word,
   input  logic [HSW-1:0]  last_word,
   input  logic [SHW-1:0]  first_enc,
   input  logic [SHW-1:0]  last_enc,
   input  logic [XLEN-1:0] rs,
   input  logic [XLEN-1:0] ra,
   input  logic [SHW-1:0]  amt_in,
   output logic [XLEN-1:0] result
);
   function automatic logic [XLEN-1:0] rotl(input logic [XLEN-1:0] v, input logic [SHW-1:0] a);
      logic [2*XLEN-1:0] t;
      t = {v, v} << a;
      return t[2*XLEN-1:XLEN];
   endfunction

   logic            use_word, do_insert;
   logic [XLEN-1:0] rot_src, rotated, mask;
   logic [SHW-1:0]  amt, dec_first, dec_last, run_first, run_last;

   assign use_word  = (op == SRM_ROTM) & word_mode;
   assign do_insert = (op == SRM_ROTM);
   assign rot_src   = use_word ? {rs[HALF-1:0], rs[HALF-1:0]} : rs;
   assign amt       = use_word ? {1'b0, amt_in[HSW-1:0]} : amt_in;
   assign rotated   = rotl(rot_src, amt);

   // encoded fields carry their top bit in the lowest field position
   assign dec_first = {first_enc[0], first_enc[SHW-1:1]};
   assign dec_last  = {last_enc[0],  last_enc[SHW-1:1]};

   always_comb begin
      run_first = '0;
      run_last  = '1;
      case (op)
         SRM_ROTM: begin
            if (word_mode) begin
               run_first = {1'b1, first_word};
               run_last  = {1'b1, last_word};
            end else begin
               run_first = dec_first;
               run_last  = ~amt_in;
            end
         end
         SRM_ROTL: run_first = dec_first;
         SRM_ROTR: run_last  = dec_last;
         default: ;
      endcase
   end

   srm_mask #(.XLEN(XLEN)) i_mask (
      .run_first (run_first),
      .run_last  (run_last),
      .mask      (mask)
   );

   assign result = (rotated & mask) | ({XLEN{do_insert}} & ra & ~mask);

   always_comb begin
      if (op == SRM_ROTL || op == SRM_ROTR) begin
         AST_CLEAR_OUTSIDE: assert ((result & ~mask) == '0) else $error("clear form leaked bits outside mask"); // R9 R10
      end
   end
endmodule

// File: rtl/srm_unit.sv
`timescale 1ns/1ps
// Shift / rotate / mask execution stage, purely combinational.
module srm_unit
   import srm_pkg::*;
#(
   parameter  int unsigned XLEN = 64,
   parameter  int unsigned MUXW = 2,
   localparam int unsigned SHW  = $clog2(XLEN),
   localparam int unsigned HSW  = SHW - 1,
   localparam int unsigned HALF = XLEN / 2
) (
   input  logic [SRM_OPW-1:0] op_in,
   input  logic               is_32bit,
   input  logic               is_signed,
   input  logic [HSW-1:0]     mb_word,
   input  logic [HSW-1:0]     me_word,
   input  logic [SHW-1:0]     mb_dword,
   input  logic [SHW-1:0]     me_dword,
   input  logic [XLEN-1:0]    rs,
   input  logic [XLEN-1:0]    ra,
   input  logic [XLEN-1:0]    rb,
   input  logic [MUXW-1:0]    muxid_in,
   output logic [XLEN-1:0]    result,
   output logic               result_valid,
   output logic [1:0]         carry,
   output logic [SRM_OPW-1:0] op_out,
   output logic [MUXW-1:0]    muxid_out
);
   if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("XLEN must be a power of two of at least 8");
   end
   if (MUXW < 1) begin : g_bad_muxw
      $error("MUXW must be at least 1");
   end

   srm_op_e         opc;
   logic [XLEN-1:0] shf_res, rot_res;
   logic [1:0]      shf_carry;
   logic [XLEN-SHW-2:0] unused_rb_hi;

   assign opc          = srm_op_e'(op_in);
   assign unused_rb_hi = rb[XLEN-1:SHW+1];

   srm_shifter #(.XLEN(XLEN)) i_shifter (
      .op        (opc),
      .is_32bit  (is_32bit),
      .is_signed (is_signed),
      .rs        (rs),
      .amt_in    (rb[SHW:0]),
      .result    (shf_res),
      .carry     (shf_carry)
   );

   srm_rotator #(.XLEN(XLEN)) i_rotator (
      .op         (opc),
      .word_mode  (is_32bit),
      .first_word (mb_word),
      .last_word  (me_word),
      .first_enc  (mb_dword),
      .last_enc   (me_dword),
      .rs         (rs),
      .ra         (ra),
      .amt_in     (rb[SHW-1:0]),
      .result     (rot_res)
   );

   always_comb begin
      result_valid = 1'b1;
      result       = '0;
      case (opc)
         SRM_SHL, SRM_SHR, SRM_EXTSL: result = shf_res;
         SRM_ROTM, SRM_ROTL, SRM_ROTR: result = rot_res;
         default: result_valid = 1'b0;
      endcase
   end

   assign carry     = shf_carry;
   assign op_out    = op_in;
   assign muxid_out = muxid_in;

   always_comb begin
      if (!result_valid) begin
         AST_IDLE_QUIET: assert (result == '0 && carry == 2'b00) else $error("foreign opcode produced data"); // R12
      end
      if (opc != SRM_SHR) begin
         AST_NO_CARRY: assert (carry == 2'b00) else $error("carry outside right shift"); // R4
      end
      if (opc == SRM_SHL && is_32bit) begin
         AST_SHL_WORD_HIGH: assert (result[XLEN-1:HALF] == '0) else $error("word left shift upper half not clear"); // R1
      end
   end
endmodule

// File: tb/test_srm_unit.sv
`timescale 1ns/1ps
module test_srm_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [3:0]  op_in;
   logic        is_32bit, is_signed;
   logic [4:0]  mb_word, me_word;
   logic [5:0]  mb_dword, me_dword;
   logic [63:0] rs, ra, rb;
   logic [1:0]  muxid_in;
   logic [63:0] result;
   logic        result_valid;
   logic [1:0]  carry;
   logic [3:0]  op_out;
   logic [1:0]  muxid_out;

   srm_unit i_srm_unit (
      .op_in(op_in), .is_32bit(is_32bit), .is_signed(is_signed),
      .mb_word(mb_word), .me_word(me_word), .mb_dword(mb_dword), .me_dword(me_dword),
      .rs(rs), .ra(ra), .rb(rb), .muxid_in(muxid_in),
      .result(result), .result_valid(result_valid), .carry(carry),
      .op_out(op_out), .muxid_out(muxid_out)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(string rq, string what, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // ---------------- reference model built from the requirements ----------------
   function automatic logic [63:0] bmask(int f, int l);
      logic [63:0] m = '0;
      if (f <= l) begin
         for (int i = f; i <= l; i++) m[63-i] = 1'b1;
      end else begin
         for (int i = l + 1; i < f; i++) m[63-i] = 1'b1;
         m = ~m;
      end
      return m;
   endfunction

   function automatic logic [63:0] brot(logic [63:0] v, int a);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[(i + a) % 64] = v[i];
      return r;
   endfunction

   function automatic int dec6(logic [5:0] f);
      return int'(f[0]) * 32 + int'(f[5:1]);
   endfunction

   task automatic model(output logic [63:0] res, output logic [1:0] cy, output logic v);
      int a;
      logic [63:0] src, m, rot;
      logic neg, lost;
      logic [127:0] wide;
      res = '0; cy = 2'b00; v = 1'b0;
      case (op_in)
         4'd1: begin
            v = 1'b1;
            if (is_32bit) begin
               src = rs << rb[5:0];
               res = {32'h0, src[31:0]};
            end else begin
               a = int'(rb[6:0]);
               res = (a >= 64) ? 64'h0 : rs << a;
            end
         end
         4'd2: begin
            v = 1'b1;
            if (is_32bit) begin
               src = is_signed ? {{32{rs[31]}}, rs[31:0]} : {32'h0, rs[31:0]};
               a = int'(rb[5:0]);
            end else begin
               src = rs;
               a = int'(rb[6:0]);
            end
            neg  = is_signed & src[63];
            wide = {{64{neg}}, src};
            for (int i = 0; i < 64; i++) res[i] = (i + a < 128) ? wide[i+a] : neg;
            lost = 1'b0;
            for (int j = 0; j < 64; j++) if (j < a) lost |= src[j];
            cy = {2{neg & lost}};
         end
         4'd3: begin
            v = 1'b1;
            if (is_32bit) begin
               rot = brot({rs[31:0], rs[31:0]}, int'(rb[4:0]));
               m   = bmask(32 + int'(mb_word), 32 + int'(me_word));
            end else begin
               rot = brot(rs, int'(rb[5:0]));
               m   = bmask(dec6(mb_dword), 63 - int'(rb[5:0]));
            end
            res = (rot & m) | (ra & ~m);
         end
         4'd4: begin
            v = 1'b1;
            res = brot(rs, int'(rb[5:0])) & bmask(dec6(mb_dword), 63);
         end
         4'd5: begin
            v = 1'b1;
            res = brot(rs, int'(rb[5:0])) & bmask(0, dec6(me_dword));
         end
         4'd6: begin
            v = 1'b1;
            res = {{32{rs[31]}}, rs[31:0]} << rb[5:0];
         end
         default: ;
      endcase
   endtask

   // drive one vector, compare against the model and the pass-through rule
   task automatic apply(string rq, logic [3:0] op, bit w, bit s, logic [4:0] mbw, logic [4:0] mew,
                        logic [5:0] mbd, logic [5:0] med, logic [63:0] vs, logic [63:0] va, logic [63:0] vb);
      logic [63:0] er; logic [1:0] ec; logic ev;
      @(negedge clk);
      op_in = op; is_32bit = w; is_signed = s;
      mb_word = mbw; me_word = mew; mb_dword = mbd; me_dword = med;
      rs = vs; ra = va; rb = vb; muxid_in = 2'($urandom);
      #2;
      model(er, ec, ev);
      chk(rq, "valid/carry/result", {result_valid, carry, result}, {ev, ec, er});
      chk("R12", "pass-through", {op_out, muxid_out}, {op_in, muxid_in});
   endtask

   function automatic logic [63:0] r64();
      return {$urandom, $urandom};
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_idle();
      chk("R12", "idle valid", result_valid, 1'b0);
      chk("R12", "idle result", result, 64'h0);
      chk("R4", "idle carry", carry, 2'b00);
   endtask

   task automatic t_shl();
      int amts[7] = '{0, 1, 31, 32, 63, 64, 127};
      foreach (amts[k]) begin
         apply("R1", 4'd1, 1'b0, 1'b0, 0, 0, 0, 0, 64'hF0F0_1234_5678_9ABC, 64'hFFFF, {57'h1ABCDEF, 7'(amts[k])});
         apply("R1", 4'd1, 1'b1, 1'b0, 0, 0, 0, 0, 64'hF0F0_1234_5678_9ABC, 64'hFFFF, {57'h1ABCDEF, 7'(amts[k])});
      end
      apply("R1", 4'd1, 1'b0, 1'b0, 0, 0, 0, 0, 64'h1, 64'h0, 64'd63);
      chk("R1", "msb from shift by 63", result, 64'h8000_0000_0000_0000);
      apply("R1", 4'd1, 1'b1, 1'b0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd4);
      chk("R1", "word shift upper clear", result, 64'h0000_0000_FFFF_FFF0);
      apply("R1", 4'd1, 1'b0, 1'b0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd64);
      chk("R1", "shift by 64 is zero", result, 64'h0);
   endtask

   task automatic t_shr();
      int amts[7] = '{0, 1, 31, 32, 63, 64, 127};
      foreach (amts[k]) begin
         for (int m = 0; m < 4; m++) begin
            apply("R2", 4'd2, m[0], m[1], 0, 0, 0, 0, 64'h8765_4321_8000_0003, 64'h0, {57'h0F0F, 7'(amts[k])});
            apply("R3", 4'd2, m[0], m[1], 0, 0, 0, 0, 64'hF000_0000_8000_0000, 64'h0, {57'h0, 7'(amts[k])});
         end
      end
      apply("R3", 4'd2, 1'b1, 1'b1, 0, 0, 0, 0, 64'h0000_0000_8000_0001, 64'h0, 64'd1);
      chk("R3", "word signed shift data", result, 64'hFFFF_FFFF_C000_0000);
      chk("R3", "word signed shift carry", carry, 2'b11);
      apply("R3", 4'd2, 1'b0, 1'b1, 0, 0, 0, 0, 64'h8000_0000_0000_0000, 64'h0, 64'd63);
      chk("R3", "only zeros shifted out", {carry, result}, {2'b00, 64'hFFFF_FFFF_FFFF_FFFF});
      apply("R3", 4'd2, 1'b0, 1'b1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd100);
      chk("R3", "overlong signed shift", {carry, result}, {2'b11, 64'hFFFF_FFFF_FFFF_FFFF});
      apply("R4", 4'd2, 1'b0, 1'b0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd8);
      chk("R4", "unsigned shift no carry", {carry, result}, {2'b00, 64'h00FF_FFFF_FFFF_FFFF});
   endtask

   task automatic t_rotate();
      apply("R6", 4'd3, 1'b1, 1'b0, 5'd0, 5'd31, 0, 0, 64'hAAAA_AAAA_1234_5678, 64'h0, 64'd4);
      chk("R6", "word rotate low half", result, 64'h0000_0000_2345_6781);
      apply("R5", 4'd3, 1'b1, 1'b0, 5'd16, 5'd15, 0, 0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      chk("R5", "wrapped full mask", result, 64'h0000_0001_0000_0001);
      apply("R5", 4'd3, 1'b1, 1'b0, 5'd5, 5'd5, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd0);
      chk("R5", "single bit mask", result, 64'h0000_0000_0400_0000);
      apply("R8", 4'd3, 1'b0, 1'b0, 0, 0, 6'b000010, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd0);
      chk("R8", "decoded first position 1", result, 64'h7FFF_FFFF_FFFF_FFFF);
      apply("R7", 4'd3, 1'b0, 1'b0, 0, 0, 6'd0, 0, 64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8);
      chk("R7", "insert with moving end", result, 64'h0000_0000_0000_FFFF);
      apply("R9", 4'd4, 1'b0, 1'b0, 0, 0, 6'b000001, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      chk("R9", "clear left ignores ra", result, 64'h0000_0000_FFFF_FFFF);
      apply("R10", 4'd5, 1'b0, 1'b0, 0, 0, 0, 6'b000000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      chk("R10", "clear right me 0", result, 64'h8000_0000_0000_0000);
      apply("R10", 4'd5, 1'b0, 1'b0, 0, 0, 0, 6'b000001, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      chk("R8", "decoded last position 32", result, 64'hFFFF_FFFF_8000_0000);
   endtask

   task automatic t_extsl();
      apply("R11", 4'd6, 1'b0, 1'b0, 0, 0, 0, 0, 64'h1234_5678_8000_0000, 64'h0, 64'd4);
      chk("R11", "negative word", result, 64'hFFFF_FFF8_0000_0000);
      apply("R11", 4'd6, 1'b0, 1'b0, 0, 0, 0, 0, 64'hFFFF_FFFF_0000_0001, 64'h0, 64'd63);
      chk("R11", "positive word max shift", result, 64'h8000_0000_0000_0000);
      chk("R4", "extend no carry", carry, 2'b00);
   endtask

   task automatic t_foreign();
      for (int op = 7; op < 17; op++) begin
         apply("R12", 4'(op % 16), op[0], op[1], 5'h1F, 5'h0, 6'h3F, 6'h0,
               64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
         chk("R12", "foreign opcode quiet", {result_valid, carry, result}, 67'h0);
      end
   endtask

   task automatic t_sweep();
      string tags[7] = '{"R12", "R1", "R2", "R7", "R9", "R10", "R11"};
      for (int op = 1; op < 7; op++) begin
         for (int n = 0; n < 120; n++) begin
            apply(tags[op], 4'(op), 1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom),
                  6'($urandom), 6'($urandom), r64(), r64(), r64());
         end
      end
   endtask

   initial begin
      op_in = '0; is_32bit = 0; is_signed = 0; mb_word = '0; me_word = '0;
      mb_dword = '0; me_dword = '0; rs = '0; ra = '0; rb = '0; muxid_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_idle();
      rst_n = 1'b1;
      t_shl();
      t_shr();
      t_rotate();
      t_extsl();
      t_foreign();
      t_sweep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule